// File: doc/BRIEF.md
# GPIO Signal Crossbar

This block sits between a bank of GPIO pads and the on-chip peripherals. Each pad has two programmable byte-wide selectors: one picks the signal that drives the pad's output value, and the other picks the signal that decides whether the pad drives at all. Each peripheral input has a selector that picks the pad whose level it receives. All selectors sit in 32-bit words that a simple register port can write and read. Each word holds four byte lanes, and selector N is in word N/4 at bit offset 8*(N%4).

Pad levels enter through a two-flop synchronizer. The synchronized levels feed the peripheral inputs and a status word. Selector code 0 always means constant low and code 1 always means constant high, so real sources start at code 2. Software changes one pin by writing only that pin's byte lane with byte enables.

With the default parameters the word map is:

| Words | Contents |
|-------|----------|
| 0–1 | output-value selectors |
| 2–3 | output-enable selectors |
| 4–5 | peripheral-input selectors |
| 6 | status |

Top module: `gpio_xbar`

## Requirements
- R1: After reset, every output-value selector reads 0, every output-enable selector reads 1 (pad not driven, pad_oe low), and every input selector reads 0 (peripheral input low). For example, word 2 reads 0x01010101.
- R2: Output-value selector codes:
  - code 0 drives the pad low;
  - code 1 drives it high;
  - code 2+k drives it from periph_out[k];
  - any code at or above N_POUT+2 drives it low.
- R3: The output-enable selector is a 6-bit field in bits [5:0] of its lane, and bits [7:6] read back as 0. Its codes:
  - code 0 drives the pad (pad_oe high);
  - code 1 releases it;
  - code 2+k follows the active-low periph_oen[k];
  - any code at or above N_POEN+2 releases the pad.
- R4: Peripheral-input selector codes:
  - code 0 gives 0;
  - code 1 gives 1;
  - code 2+p gives the synchronized level of pad p;
  - any code at or above N_PADS+2 gives 0.
- R5: A write changes only the byte lanes whose reg_be bit is set. The other lanes of the word keep their value.
- R6: A pad level change reaches periph_in and the status word after exactly two rising clock edges.
- R7: The status word (word 6 by default) shows the synchronized level of pad N at bit N%32 of word N/32 after the status base.
- R8: Selector N of each group lives in word (group base + N/4), bits [8*(N%4)+7 : 8*(N%4)]. Reads return the stored fields, and a configuration change shows on the outputs one cycle after the write edge.
- R9: Writes to the status word or to unmapped addresses change no selector, and unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address for read and write |
| reg_be | input | 4 | Byte-lane write enables |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| periph_out | input | N_POUT | Peripheral signals that may drive pad values |
| periph_oen | input | N_POEN | Peripheral active-low drive enables |
| periph_in | output | N_PIN | Routed pad levels delivered to peripherals |
| pad_in | input | N_PADS | Raw pad input levels |
| pad_out | output | N_PADS | Pad output values |
| pad_oe | output | N_PADS | Pad drive enables, active high |

## Verification
The hardest case to reach from the ports is a partial-lane write. Its effect only shows when a lane that is not enabled would change an output if it were written. The stimulus therefore writes 0xFF into the three disabled lanes, and the bench expects an output pattern that only the old codes produce. Out-of-range codes need the same care: they are driven together with all-ones source vectors, so that a decoder which wraps or aliases would show a 1 where the bench expects 0. The synchronizer latency is checked by changing a pad right after an edge and sampling one edge and then two edges later.

// File: rtl/gpio_xbar_pkg.sv
// Shared constants for the GPIO crossbar: selector widths and the fixed codes.
package gpio_xbar_pkg;
    localparam int SEL_W     = 8;   // byte-wide selector field
    localparam int OE_W      = 6;   // stored width of an output-enable selector
    localparam int CODE_BASE = 2;   // first code that names a real source
    localparam logic [SEL_W-1:0] SEL_LOW  = 8'd0;
    localparam logic [SEL_W-1:0] SEL_HIGH = 8'd1;
    localparam logic [OE_W-1:0]  OE_DRIVE = 6'd0;
    localparam logic [OE_W-1:0]  OE_FLOAT = 6'd1;
endpackage

// File: rtl/xbar_pad_sync.sv
// Two-flop synchronizer for the pad input levels.
// Assumes pad levels are asynchronous to clk; reset clears both stages.
module xbar_pad_sync #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] meta;

    // Two capture stages; q is the second stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

    // R6: output equals the input seen two edges earlier once out of reset
    p_sync_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (q == $past(d, 2)));
endmodule

// File: rtl/xbar_cfg_regs.sv
// Selector register file for the GPIO crossbar.
// Holds the output-value, output-enable and peripheral-input selectors,
// packed four per 32-bit word. Byte enables gate each lane. Reads are
// combinational from reg_addr. The status word returns the synchronized pad levels.
module xbar_cfg_regs
    import gpio_xbar_pkg::*;
#(
    parameter int N_PADS = 8,
    parameter int N_PIN  = 8,
    parameter int ADDR_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_we,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [3:0]                    reg_be,
    input  logic [31:0]                   reg_wdata,
    input  logic [N_PADS-1:0]             pad_lvl,
    output logic [31:0]                   reg_rdata,
    output logic [N_PADS-1:0][SEL_W-1:0]  out_sel,
    output logic [N_PADS-1:0][OE_W-1:0]   oe_sel,
    output logic [N_PIN-1:0][SEL_W-1:0]   in_sel
);
    localparam int PAD_WORDS = (N_PADS + 3) / 4;
    localparam int PIN_WORDS = (N_PIN + 3) / 4;
    localparam int OUT_BASE  = 0;
    localparam int OE_BASE   = OUT_BASE + PAD_WORDS;
    localparam int IN_BASE   = OE_BASE + PAD_WORDS;
    localparam int STAT_BASE = IN_BASE + PIN_WORDS;

    // Lane-gated selector updates; reset puts every selector at its safe code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_PADS; i++) begin
                out_sel[i] <= SEL_LOW;
                oe_sel[i]  <= OE_FLOAT;
            end
            for (int j = 0; j < N_PIN; j++) in_sel[j] <= SEL_LOW;
        end else if (reg_we) begin
            for (int i = 0; i < N_PADS; i++) begin
                if (reg_addr == ADDR_W'(OUT_BASE + i / 4) && reg_be[i % 4])
                    out_sel[i] <= reg_wdata[8*(i % 4) +: SEL_W];
                if (reg_addr == ADDR_W'(OE_BASE + i / 4) && reg_be[i % 4])
                    oe_sel[i] <= reg_wdata[8*(i % 4) +: OE_W];
            end
            for (int j = 0; j < N_PIN; j++)
                if (reg_addr == ADDR_W'(IN_BASE + j / 4) && reg_be[j % 4])
                    in_sel[j] <= reg_wdata[8*(j % 4) +: SEL_W];
        end
    end

    // Read mux: selector fields in their lanes, pad levels in the status words.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < N_PADS; i++) begin
            if (reg_addr == ADDR_W'(OUT_BASE + i / 4))
                reg_rdata[8*(i % 4) +: 8] = out_sel[i];
            if (reg_addr == ADDR_W'(OE_BASE + i / 4))
                reg_rdata[8*(i % 4) +: 8] = {2'b00, oe_sel[i]};
            if (reg_addr == ADDR_W'(STAT_BASE + i / 32))
                reg_rdata[i % 32] = pad_lvl[i];
        end
        for (int j = 0; j < N_PIN; j++)
            if (reg_addr == ADDR_W'(IN_BASE + j / 4))
                reg_rdata[8*(j % 4) +: 8] = in_sel[j];
    end

    // R5: without an enabled lane write, no selector changes
    p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && (|reg_be)) |=> ($stable(out_sel) && $stable(oe_sel) && $stable(in_sel)));
endmodule

// File: rtl/gpio_xbar.sv
// GPIO signal crossbar top.
// Decodes each pad's output-value and output-enable selector and each
// peripheral input's pad selector into plain muxes. Codes 0 and 1 are
// constants, 2+k names source k, and out-of-range codes fall back to the safe value.
// Assumes the parameters keep all codes inside their field widths.
module gpio_xbar
    import gpio_xbar_pkg::*;
#(
    parameter int N_PADS = 8,
    parameter int N_POUT = 16,
    parameter int N_POEN = 16,
    parameter int N_PIN  = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [3:0]        reg_be,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [N_POUT-1:0] periph_out,
    input  logic [N_POEN-1:0] periph_oen,
    output logic [N_PIN-1:0]  periph_in,
    input  logic [N_PADS-1:0] pad_in,
    output logic [N_PADS-1:0] pad_out,
    output logic [N_PADS-1:0] pad_oe
);
    logic [N_PADS-1:0][SEL_W-1:0] out_sel;
    logic [N_PADS-1:0][OE_W-1:0]  oe_sel;
    logic [N_PIN-1:0][SEL_W-1:0]  in_sel;
    logic [N_PADS-1:0]            pad_sync;

    xbar_pad_sync #(.N(N_PADS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_sync)
    );

    xbar_cfg_regs #(.N_PADS(N_PADS), .N_PIN(N_PIN), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .pad_lvl(pad_sync),
        .reg_rdata(reg_rdata), .out_sel(out_sel), .oe_sel(oe_sel), .in_sel(in_sel)
    );

    for (genvar p = 0; p < N_PADS; p++) begin : g_pad
        logic oen_n;

        // Output value: constants, then peripheral sources, else low.
        always_comb begin
            pad_out[p] = (out_sel[p] == SEL_HIGH);
            for (int k = 0; k < N_POUT; k++)
                if (out_sel[p] == SEL_W'(k + CODE_BASE)) pad_out[p] = periph_out[k];
        end

        // Active-low enable: drive code, peripheral enables, else released.
        always_comb begin
            oen_n = (oe_sel[p] != OE_DRIVE);
            for (int k = 0; k < N_POEN; k++)
                if (oe_sel[p] == OE_W'(k + CODE_BASE)) oen_n = periph_oen[k];
        end
        assign pad_oe[p] = ~oen_n;

        // R2: the constant-high code always drives a 1
        p_out_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (out_sel[p] == SEL_HIGH) |-> pad_out[p]);
        // R3: the drive code enables the pad
        p_oe_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (oe_sel[p] == OE_DRIVE) |-> pad_oe[p]);
        // R3: codes past the last enable source release the pad
        p_oe_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(oe_sel[p]) >= N_POEN + CODE_BASE) |-> !pad_oe[p]);
    end

    for (genvar j = 0; j < N_PIN; j++) begin : g_pin
        // Peripheral input: constants, then synchronized pads, else low.
        always_comb begin
            periph_in[j] = (in_sel[j] == SEL_HIGH);
            for (int p = 0; p < N_PADS; p++)
                if (in_sel[j] == SEL_W'(p + CODE_BASE)) periph_in[j] = pad_sync[p];
        end

        // R4: the constant-low code and out-of-range codes give 0
        p_in_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ((in_sel[j] == SEL_LOW) || (int'(in_sel[j]) >= N_PADS + CODE_BASE)) |-> !periph_in[j]);
    end

    // R1: the cycle after reset no pad is driven and all peripheral inputs are low
    p_reset_safe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pad_oe == '0 && periph_in == '0 && pad_out == '0));
endmodule

// File: tb/tb_gpio_xbar.sv
module tb_gpio_xbar;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] periph_out = '0;
    logic [15:0] periph_oen = '0;
    logic [7:0]  periph_in;
    logic [7:0]  pad_in = 8'hFF;
    logic [7:0]  pad_out;
    logic [7:0]  pad_oe;

    int n_tests = 0;
    int n_fail  = 0;

    gpio_xbar dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .periph_out(periph_out), .periph_oen(periph_oen), .periph_in(periph_in),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    always #5 clk = ~clk;

    typedef struct packed {
        logic [3:0]  addr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [15:0] pout;
        logic [15:0] poen;
        logic [7:0]  pads;
        logic [7:0]  e_out;
        logic [7:0]  e_oe;
        logic [7:0]  e_in;
        logic [7:0]  req;
    } vec_t;

    // Each row is one write and the inputs held with it; state carries over between rows.
    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{4'd0, 4'hF, 32'h11020001, 16'h8001, 16'h0000, 8'h00, 8'h0D, 8'h00, 8'h00, 8'd2}, // R2 const, src0, src15
        '{4'd0, 4'hF, 32'h12030100, 16'hFFFF, 16'h0000, 8'h00, 8'h06, 8'h00, 8'h00, 8'd2}, // R2 out-of-range code low
        '{4'd2, 4'hF, 32'h3F020100, 16'hFFFF, 16'h0000, 8'h00, 8'h06, 8'h05, 8'h00, 8'd3}, // R3 drive, release, src, range
        '{4'd2, 4'hF, 32'h11020001, 16'hFFFF, 16'h8001, 8'h00, 8'h06, 8'h02, 8'h00, 8'd3}, // R3 active-low sources
        '{4'd4, 4'hF, 32'h09020100, 16'hFFFF, 16'h8001, 8'h81, 8'h06, 8'h02, 8'h0E, 8'd4}, // R4 constants, pad0, pad7
        '{4'd4, 4'hF, 32'hFF04050A, 16'hFFFF, 16'h8001, 8'h08, 8'h06, 8'h02, 8'h02, 8'd4}, // R4 out-of-range codes
        '{4'd0, 4'h4, 32'hFF01FFFF, 16'h0000, 16'h8001, 8'h08, 8'h06, 8'h02, 8'h02, 8'd5}, // R5 single lane
        '{4'd5, 4'h1, 32'h00000003, 16'h0000, 16'h8001, 8'h0A, 8'h06, 8'h02, 8'h12, 8'd8}, // R8 second input word
        '{4'd1, 4'h8, 32'h01000000, 16'h0000, 16'h8001, 8'h0A, 8'h86, 8'h02, 8'h12, 8'd8}  // R8 second pad word
    };

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_be = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "pad_out", {24'b0, pad_out}, 32'h0);
        check("R1", "pad_oe", {24'b0, pad_oe}, 32'h0);
        check("R1", "periph_in", {24'b0, periph_in}, 32'h0);
        rd(4'd2, r); check("R1", "oe word", r, 32'h01010101);
        rd(4'd4, r); check("R1", "in word", r, 32'h0);
        // R7 status after pads settle through the synchronizer
        rd(4'd6, r); check("R7", "status all high", r, 32'h000000FF);

        for (int v = 0; v < NV; v++) begin
            periph_out = VECS[v].pout;
            periph_oen = VECS[v].poen;
            pad_in     = VECS[v].pads;
            wr(VECS[v].addr, VECS[v].be, VECS[v].wdata);
            repeat (3) @(negedge clk);
            check($sformatf("R%0d", VECS[v].req), $sformatf("vec%0d pad_out", v), {24'b0, pad_out}, {24'b0, VECS[v].e_out});
            check($sformatf("R%0d", VECS[v].req), $sformatf("vec%0d pad_oe", v), {24'b0, pad_oe}, {24'b0, VECS[v].e_oe});
            check($sformatf("R%0d", VECS[v].req), $sformatf("vec%0d periph_in", v), {24'b0, periph_in}, {24'b0, VECS[v].e_in});
        end

        // R8 readback of lane placement; R5 untouched lanes kept
        rd(4'd0, r); check("R8", "out word0", r, 32'h12010100);
        rd(4'd1, r); check("R8", "out word1", r, 32'h01000000);
        rd(4'd5, r); check("R8", "in word1", r, 32'h00000003);
        // R3 field is 6 bits wide; bits 7:6 read as zero and codes 63 release
        wr(4'd3, 4'hF, 32'hFFFFFFFF);
        rd(4'd3, r); check("R3", "oe width", r, 32'h3F3F3F3F);
        check("R3", "pad_oe after 63", {24'b0, pad_oe}, 32'h02);
        // R9 writes to unmapped and status addresses change nothing
        wr(4'd7, 4'hF, 32'hFFFFFFFF);
        rd(4'd7, r); check("R9", "unmapped read", r, 32'h0);
        wr(4'd6, 4'hF, 32'h00000000);
        rd(4'd6, r); check("R9", "status unwritable", r, 32'h0000000A);
        check("R9", "pad_out unchanged", {24'b0, pad_out}, 32'h86);
        rd(4'd15, r); check("R9", "high unmapped read", r, 32'h0);

        // R6 two-edge latency: input 1 follows pad3, input 4 follows pad1
        @(negedge clk);
        pad_in = 8'h02;
        @(negedge clk);
        check("R6", "after one edge", {24'b0, periph_in}, 32'h12);
        @(negedge clk);
        check("R6", "after two edges", {24'b0, periph_in}, 32'h10);

        // R7 bit position of a single pad
        pad_in = 8'h40;
        repeat (2) @(negedge clk);
        rd(4'd6, r); check("R7", "status bit6", r, 32'h00000040);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule